// File: doc/BRIEF.md
# FFT Bin Order Restorer

This block sits at the tail of a radix-2 decimation-in-frequency FFT pipeline. The last butterfly stage delivers the 32 complex bins of each transform in bit-reversed index order: the even-numbered bins come out in the first half of the frame and the odd-numbered bins in the second half. The block stores each frame and plays it back in natural bin order, 0 through 31. Downstream logic can then consume the spectrum directly.

Two frame-sized storage banks swap roles at every frame boundary. Incoming samples are written into one bank at the bit-reversed position of their arrival count, while the other bank is read out at the plain count. Frames may therefore arrive back to back with no stall. Input samples are qualified by a single enable, and the output stream is marked by its own enable. Idle cycles between input samples are allowed anywhere, including inside a frame.

Top module: `fft_bitrev_reorder`

## Requirements
- R1: After reset, `out_en` is low and both output words are zero. Reset discards any partly captured frame, and `out_en` stays low until 32 samples have been accepted since reset.
- R2: When the 32nd sample of a frame is accepted on clock edge n, bin 0 of that frame appears with `out_en` high after edge n+1, and not earlier.
- R3: The k-th word pair of an output frame (k = 0..31) equals the input sample accepted at position p of that frame, where p is k with its 5 bits reversed (bit 0 swapped with bit 4, bit 1 with bit 3, bit 2 kept).
- R4: For a frame followed by a pause, `out_en` is high for exactly 32 consecutive cycles.
- R5: Frames accepted back to back with no idle input cycle come out as one unbroken run of `out_en` (32 cycles per frame), each frame correct as in R3.
- R6: A cycle with `in_en` low accepts nothing: its data is ignored and the in-frame position does not advance, so gaps inside a frame leave the reordered output unchanged.
- R7: Whenever `out_en` is low, `out_re` and `out_im` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_en | input | 1 | Input sample valid |
| in_re | input | 16 | Real part of the incoming bin |
| in_im | input | 16 | Imaginary part of the incoming bin |
| out_en | output | 1 | Output sample valid |
| out_re | output | 16 | Real part of the natural-order bin |
| out_im | output | 16 | Imaginary part of the natural-order bin |

## Verification
The assertions expect nothing of `in_en`. Any pattern of accepted and idle cycles is legal, because readout drains one bank at one word per cycle and so finishes no later than the writer can refill it. From that they derive that no more than one finished frame ever waits, that output runs end on frame boundaries, and that no output appears before a full frame exists. The stimulus therefore covers an incomplete frame, a reset in the middle of a frame, a frame with scattered idle cycles, an isolated frame and an unbroken train of three frames. All data values are defined, and each frame's values are distinct so that any misplaced bin shows up.

// File: rtl/fft_reorder_pkg.sv
package fft_reorder_pkg;

    localparam int DEF_DATA_W = 16;
    localparam int DEF_LOG2_N = 5;
    localparam int NUM_BANKS  = 2;

    typedef enum logic {
        BANK_0 = 1'b0,
        BANK_1 = 1'b1
    } bank_e;

    function automatic bank_e other_bank(bank_e b);
        return (b == BANK_0) ? BANK_1 : BANK_0;
    endfunction

endpackage

// File: rtl/fft_reorder_wr.sv
module fft_reorder_wr
    import fft_reorder_pkg::*;
#(
    parameter int LOG2_N = DEF_LOG2_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_en,
    output logic [LOG2_N-1:0] cnt,
    output logic [LOG2_N-1:0] waddr,
    output bank_e             wbank,
    output logic              frame_done
);
    localparam logic [LOG2_N-1:0] LAST_IDX = {LOG2_N{1'b1}};

    // bit-reversed write address, one wire per bit
    for (genvar b = 0; b < LOG2_N; b++) begin : g_rev
        assign waddr[b] = cnt[LOG2_N-1-b];
    end

    assign frame_done = in_en && (cnt == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            wbank <= BANK_0;
        end else if (in_en) begin
            cnt <= cnt + 1'b1;
            if (frame_done) begin
                wbank <= other_bank(wbank);
            end
        end
    end
endmodule

// File: rtl/fft_reorder_mem.sv
module fft_reorder_mem
    import fft_reorder_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int LOG2_N = DEF_LOG2_N
) (
    input  logic                clk,
    input  logic                we,
    input  bank_e               wbank,
    input  logic [LOG2_N-1:0]   waddr,
    input  logic [2*DATA_W-1:0] wdata,
    input  bank_e               rbank,
    input  logic [LOG2_N-1:0]   raddr,
    output logic [2*DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << LOG2_N;

    logic [2*DATA_W-1:0] bank_rd [NUM_BANKS];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic [2*DATA_W-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (we && (wbank == bank_e'(g))) begin
                store[waddr] <= wdata;
            end
        end

        assign bank_rd[g] = store[raddr];
    end

    assign rdata = (rbank == BANK_1) ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/fft_reorder_rd.sv
module fft_reorder_rd
    import fft_reorder_pkg::*;
#(
    parameter int LOG2_N = DEF_LOG2_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_done,
    output logic              rd_go,
    output logic [LOG2_N-1:0] raddr,
    output bank_e             rbank,
    output logic [1:0]        avail
);
    localparam logic [LOG2_N-1:0] LAST_IDX = {LOG2_N{1'b1}};

    logic rd_last;

    assign rd_go   = (avail != 2'd0);
    assign rd_last = rd_go && (raddr == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            avail <= 2'd0;
            raddr <= '0;
            rbank <= BANK_0;
        end else begin
            avail <= avail + {1'b0, frame_done} - {1'b0, rd_last};
            if (rd_go) begin
                raddr <= raddr + 1'b1;
            end
            if (rd_last) begin
                rbank <= other_bank(rbank);
            end
        end
    end
endmodule

// File: rtl/fft_bitrev_reorder.sv
module fft_bitrev_reorder
    import fft_reorder_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int LOG2_N = DEF_LOG2_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_en,
    input  logic [DATA_W-1:0] in_re,
    input  logic [DATA_W-1:0] in_im,
    output logic              out_en,
    output logic [DATA_W-1:0] out_re,
    output logic [DATA_W-1:0] out_im
);
    logic [LOG2_N-1:0]   wr_cnt;
    logic [LOG2_N-1:0]   wr_addr;
    bank_e               wr_bank;
    logic                wr_frame_done;
    logic                rd_go;
    logic [LOG2_N-1:0]   rd_addr;
    bank_e               rd_bank;
    logic [1:0]          rd_avail;
    logic [2*DATA_W-1:0] rd_word;

    fft_reorder_wr #(.LOG2_N(LOG2_N)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .in_en      (in_en),
        .cnt        (wr_cnt),
        .waddr      (wr_addr),
        .wbank      (wr_bank),
        .frame_done (wr_frame_done)
    );

    fft_reorder_mem #(.DATA_W(DATA_W), .LOG2_N(LOG2_N)) u_mem (
        .clk   (clk),
        .we    (in_en),
        .wbank (wr_bank),
        .waddr (wr_addr),
        .wdata ({in_re, in_im}),
        .rbank (rd_bank),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    fft_reorder_rd #(.LOG2_N(LOG2_N)) u_rd (
        .clk        (clk),
        .rst        (rst),
        .frame_done (wr_frame_done),
        .rd_go      (rd_go),
        .raddr      (rd_addr),
        .rbank      (rd_bank),
        .avail      (rd_avail)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_en <= 1'b0;
            out_re <= '0;
            out_im <= '0;
        end else begin
            out_en <= rd_go;
            out_re <= rd_go ? rd_word[2*DATA_W-1:DATA_W] : '0;
            out_im <= rd_go ? rd_word[DATA_W-1:0]        : '0;
        end
    end
endmodule

// File: rtl/fft_reorder_chk.sv
module fft_reorder_chk #(
    parameter int DATA_W = 16,
    parameter int LOG2_N = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              in_en,
    input logic [LOG2_N-1:0] wr_cnt,
    input logic [1:0]        avail,
    input logic              out_en,
    input logic [DATA_W-1:0] out_re,
    input logic [DATA_W-1:0] out_im
);
    logic              got_frame;
    logic [LOG2_N-1:0] run_pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            got_frame <= 1'b0;
            run_pos   <= '0;
        end else begin
            if (in_en && (wr_cnt == {LOG2_N{1'b1}})) got_frame <= 1'b1;
            if (out_en) run_pos <= run_pos + 1'b1;
        end
    end

    AST_NO_EARLY_OUT: assert property (@(posedge clk) disable iff (rst)
        out_en |-> got_frame);                                     // R1

    AST_RUN_FRAME_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        $fell(out_en) |-> (run_pos == '0));                        // R4

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        avail <= 2'd1);                                            // R5

    AST_IDLE_HOLDS_POS: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> $stable(wr_cnt));                               // R6

    AST_ACCEPT_STEPS_POS: assert property (@(posedge clk) disable iff (rst)
        in_en |=> (wr_cnt == $past(wr_cnt) + 1'b1));               // R6

    AST_QUIET_OUTPUT: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (out_re == '0 && out_im == '0));               // R7
endmodule

bind fft_bitrev_reorder fft_reorder_chk #(.DATA_W(DATA_W), .LOG2_N(LOG2_N)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .in_en  (in_en),
    .wr_cnt (wr_cnt),
    .avail  (rd_avail),
    .out_en (out_en),
    .out_re (out_re),
    .out_im (out_im)
);

// File: tb/fft_bitrev_reorder_test.sv
module fft_bitrev_reorder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_en = 1'b0;
    logic [15:0] in_re = '0;
    logic [15:0] in_im = '0;
    logic        out_en;
    logic [15:0] out_re, out_im;

    int checks = 0;
    int bad    = 0;
    int sc     = 0;
    int cur_run = 0;
    int last_run = 0;
    int total_en = 0;
    bit finished = 0;
    string data_tag = "R3";

    always #5 clk = ~clk;

    fft_bitrev_reorder uut (
        .clk(clk), .rst(rst), .in_en(in_en), .in_re(in_re), .in_im(in_im),
        .out_en(out_en), .out_re(out_re), .out_im(out_im)
    );

    // behavioural reference model
    logic [31:0] fbuf [32];
    logic [31:0] rq [$];
    int          fpos = 0;
    logic        m_en = 0;
    logic [15:0] m_re = 0, m_im = 0;

    function automatic int rev5(int v);
        int r = 0;
        for (int b = 0; b < 5; b++) if (v[b]) r |= (1 << (4 - b));
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            rq.delete();
            fpos = 0;
            m_en = 0; m_re = 0; m_im = 0;
        end else begin
            if (rq.size() > 0) begin
                logic [31:0] w;
                w = rq.pop_front();
                m_en = 1; m_re = w[31:16]; m_im = w[15:0];
            end else begin
                m_en = 0; m_re = 0; m_im = 0;
            end
            if (in_en) begin
                fbuf[fpos] = {in_re, in_im};
                fpos++;
                if (fpos == 32) begin
                    for (int k = 0; k < 32; k++) rq.push_back(fbuf[rev5(k)]);
                    fpos = 0;
                end
            end
        end
    end

    // per-cycle comparison and run tracking
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (out_en !== m_en) begin
                bad++;
                $display("FAIL R4 out_en actual=%0b expected=%0b", out_en, m_en);
            end else if (m_en && (out_re !== m_re || out_im !== m_im)) begin
                bad++;
                $display("FAIL %s bin actual=%h_%h expected=%h_%h", data_tag, out_re, out_im, m_re, m_im);
            end else if (!m_en && (out_re !== 16'd0 || out_im !== 16'd0)) begin
                bad++;
                $display("FAIL R7 idle data actual=%h_%h expected=0000_0000", out_re, out_im);
            end
            if (out_en === 1'b1) begin
                cur_run++; total_en++;
            end else begin
                if (cur_run > 0) last_run = cur_run;
                cur_run = 0;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic feed(input int n, input bit gaps);
        int i = 0;
        int c = 0;
        while (i < n) begin
            @(negedge clk);
            if (gaps && (c % 3 == 1)) begin
                in_en = 0;
                in_re = 16'hDEAD; in_im = 16'hBEEF;
            end else begin
                in_en = 1;
                in_re = 16'(sc * 29 + 3);
                in_im = 16'(16'h8000 ^ (sc * 7));
                sc++; i++;
            end
            c++;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            in_en = 0;
            in_re = 16'h5555; in_im = 16'hAAAA;
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [15:0] first_re;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check(out_en === 1'b0, "R1 out_en after reset", int'(out_en), 0);
        check(out_re === 16'd0 && out_im === 16'd0, "R1 data after reset", int'(out_re), 0);

        // partial frame then reset: nothing may come out
        feed(10, 0);
        @(negedge clk); rst = 1; in_en = 0;
        @(negedge clk); rst = 0;
        feed(31, 0);
        idle(10);
        check(total_en == 0, "R1 no output before full frame", total_en, 0);

        // 32nd sample, then latency check
        first_re = 16'(sc * 29 + 3 - 31 * 29);
        feed(1, 0);
        idle(1);
        check(out_en === 1'b0, "R2 out_en one edge after last sample", int'(out_en), 0);
        idle(1);
        check(out_en === 1'b1, "R2 out_en two edges after last sample", int'(out_en), 1);
        check(out_re === first_re, "R3 bin 0 real", int'(out_re), int'(first_re));
        idle(40);
        check(last_run == 32, "R4 run length isolated frame", last_run, 32);

        // frame with idle cycles inside
        data_tag = "R6";
        feed(32, 1);
        idle(40);
        check(last_run == 32, "R6 run length gapped frame", last_run, 32);

        // three frames back to back
        data_tag = "R5";
        feed(96, 0);
        idle(110);
        check(last_run == 96, "R5 unbroken run for 3 frames", last_run, 96);
        check(out_en === 1'b0 && out_re === 16'd0 && out_im === 16'd0,
              "R7 outputs quiet after drain", int'(out_re), 0);
        check(total_en == 32 * 5, "R3 total bins emitted", total_en, 160);
        summary();
    end
endmodule